// File: doc/BRIEF.md
# Systolic FIR Multiply-Accumulate Cell

This block is a single tap-computing cell for a cascadable FIR filter array. Each clock it multiplies an 8-bit data sample by an 8-bit coefficient and adds the product to a 26-bit running sum. The data sample is broadcast to every cell of an array. The coefficient arrives from the cell to the left and leaves toward the cell to the right. Each operand carries its own mode bit that selects unsigned or two's complement interpretation. The coefficient's mode bit travels with it, so the next cell reads the value the same way.

All control inputs are captured in a register stage before they act, so every enable and clear takes effect one clock after it is presented. On its way out, the coefficient passes through zero to three decimation stages. This lets an array step coefficients more slowly than samples when it builds a decimating filter. A hold register keeps the finished sum for one clock while the accumulator restarts on the next sum, so accumulation never stalls.

Top module: `fir_mac_cell`

## Requirements
- R1: Each 8-bit operand is widened to a 9-bit signed value. When its mode bit is 1 the ninth bit is a copy of bit 7; when it is 0 the ninth bit is 0. The accumulated term is the exact product of the two widened values.
- R2: An operand pair loaded at rising edge n reaches the accumulator at edge n+3. If the cell is not selected, the pair is visible in `hold_q` after that edge.
- R3: `din_en_n`, `cin_en_n`, `rst_n`, `erase_n`, `sel` and `decim_sel` are each registered once. A level sampled at edge n-1 governs the loads at edge n.
- R4: When the registered data enable is inactive (the `din_en_n` pin was high), the data register loads zero instead of `din`.
- R5: When the registered coefficient enable is inactive, the coefficient register, its mode bit and all decimation stages keep their values.
- R6: `decim_sel` = d (0 to 3) makes `cout`/`cout_tc` show the coefficient loaded d loads before the one now in the coefficient register. With d = 0, the output shows the coefficient register itself.
- R7: The accumulator adds the sign-extended product on every clock. `hold_q` takes the same new sum on every clock except the one that follows a registered `sel` = 1; on that clock it keeps its value.
- R8: When registered erase (low) and registered `sel` (high) coincide without reset, the accumulator restarts from the current product alone. The old total stays visible in `hold_q` for that clock.
- R9: Erase while `sel` is low has no effect on the accumulator.
- R10: Reset alone (registered `rst_n` low, `erase_n` high) clears the data, coefficient, decimation, multiplier pipeline and hold registers. The accumulator is not cleared.
- R11: Reset and erase together also clear the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| din | input | 8 | Broadcast data sample |
| din_tc | input | 1 | Data mode: 1 two's complement, 0 unsigned |
| din_en_n | input | 1 | Data enable, active low, registered |
| cin | input | 8 | Coefficient from the left neighbour |
| cin_tc | input | 1 | Coefficient mode bit |
| cin_en_n | input | 1 | Coefficient enable, active low, registered |
| decim_sel | input | 2 | Number of decimation stages on the coefficient path |
| rst_n | input | 1 | Register clear, active low, registered |
| erase_n | input | 1 | Accumulator clear, active low, registered |
| sel | input | 1 | Cell select, active high, registered |
| cout | output | 8 | Coefficient toward the right neighbour |
| cout_tc | output | 1 | Mode bit travelling with `cout` |
| hold_q | output | 26 | Held sum of products |

## Verification
The assertions assume that every input is driven to a known level from the first clock. They also assume that no property looks back over an edge taken before the first three clocks have passed. The bench drives every pin at time zero and keeps reset asserted for several clocks before any check. The accumulation checks assume the running sum stays within 26 bits. The stimulus keeps every group of summed products at eight 8-bit terms, well inside that range. The arithmetic checks also assume that `sel` and erase are pulsed for exactly one clock per group. The stimulus issues them only at the fixed group boundary.

// File: rtl/fir_cell_pkg.sv
package fir_cell_pkg;

  localparam int unsigned OP_W_DEF  = 8;
  localparam int unsigned ACC_W_DEF = 26;
  localparam int unsigned NDEC_DEF  = 3;

  // control levels after the one-clock capture stage, active high
  typedef struct packed {
    logic din_en;
    logic cin_en;
    logic rst;
    logic erase;
    logic sel;
  } cell_ctl_t;

endpackage

// File: rtl/fir_cell_ctl.sv
module fir_cell_ctl
  import fir_cell_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             din_en_n,
  input  logic             cin_en_n,
  input  logic             rst_n,
  input  logic             erase_n,
  input  logic             sel,
  input  logic [SEL_W-1:0] decim_sel,
  output cell_ctl_t        ctl_q,
  output logic [SEL_W-1:0] decim_q
);

  // every control pin is captured once, so its effect lands one clock later
  always_ff @(posedge clk) begin
    ctl_q.din_en <= !din_en_n;
    ctl_q.cin_en <= !cin_en_n;
    ctl_q.rst    <= !rst_n;
    ctl_q.erase  <= !erase_n;
    ctl_q.sel    <= sel;
    decim_q      <= decim_sel;
  end

endmodule

// File: rtl/fir_cell_coef.sv
module fir_cell_coef #(
  parameter int OP_W  = 8,
  parameter int NDEC  = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             load_en,
  input  logic             clr,
  input  logic [OP_W-1:0]  cin,
  input  logic             cin_tc,
  input  logic [SEL_W-1:0] decim_q,
  output logic [OP_W-1:0]  c_val,
  output logic             c_tc,
  output logic [OP_W-1:0]  cout,
  output logic             cout_tc
);

  localparam int TOK_W = OP_W + 1;  // coefficient plus its mode bit

  logic [NDEC:0][TOK_W-1:0] tap;
  logic [TOK_W-1:0]         picked;

  // stage 0 is the coefficient register, stages 1..NDEC the decimation chain
  for (genvar k = 0; k <= NDEC; k++) begin : g_stage
    logic [TOK_W-1:0] d_in;
    logic [TOK_W-1:0] q;
    if (k == 0) begin : g_head
      assign d_in = {cin_tc, cin};
    end else begin : g_link
      assign d_in = g_stage[k-1].q;
    end
    always_ff @(posedge clk) begin
      if (clr)          q <= '0;
      else if (load_en) q <= d_in;
    end
    assign tap[k] = q;
  end

  assign {c_tc, c_val} = tap[0];

  always_comb begin
    picked = tap[0];
    for (int j = 1; j <= NDEC; j++) begin
      if (decim_q == SEL_W'(j)) picked = tap[j];
    end
  end

  assign {cout_tc, cout} = picked;

endmodule

// File: rtl/fir_cell_mac.sv
module fir_cell_mac #(
  parameter int OP_W  = 8,
  parameter int ACC_W = 26,
  localparam int XW   = OP_W + 1,
  localparam int PW   = 2 * XW
) (
  input  logic                 clk,
  input  logic                 ld_x,
  input  logic                 clr,
  input  logic                 erase,
  input  logic                 sel,
  input  logic [OP_W-1:0]      din,
  input  logic                 din_tc,
  input  logic [OP_W-1:0]      c_val,
  input  logic                 c_tc,
  output logic signed [XW-1:0] x_val,
  output logic [PW-1:0]        m1_val,
  output logic [ACC_W-1:0]     acc_val,
  output logic [ACC_W-1:0]     hold_val
);

  function automatic logic signed [XW-1:0] widen(input logic [OP_W-1:0] v,
                                                 input logic tc);
    widen = $signed({tc & v[OP_W-1], v});
  endfunction

  function automatic logic [ACC_W-1:0] grow(input logic [PW-1:0] p);
    grow = {{(ACC_W-PW){p[PW-1]}}, p};
  endfunction

  logic signed [XW-1:0] x_q;
  logic signed [XW-1:0] c_w;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] m0_q;
  logic signed [PW-1:0] m1_q;
  logic [ACC_W-1:0]     m1_ext;
  logic [ACC_W-1:0]     sum;
  logic [ACC_W-1:0]     acc_q;
  logic [ACC_W-1:0]     hold_q;
  logic                 acc_wipe;
  logic                 acc_restart;
  logic                 hold_load;

  assign c_w    = widen(c_val, c_tc);
  assign prod   = x_q * c_w;
  assign m1_ext = grow(m1_q);
  assign sum    = acc_q + m1_ext;

  assign acc_wipe    = clr & erase;
  assign acc_restart = erase & sel & !clr;
  assign hold_load   = !sel;

  always_ff @(posedge clk) begin
    if (clr)       x_q <= '0;
    else if (ld_x) x_q <= widen(din, din_tc);
    else           x_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      m0_q <= '0;
      m1_q <= '0;
    end else begin
      m0_q <= prod;
      m1_q <= m0_q;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_wipe)         acc_q <= '0;
    else if (acc_restart) acc_q <= m1_ext;
    else                  acc_q <= sum;
  end

  always_ff @(posedge clk) begin
    if (clr)            hold_q <= '0;
    else if (hold_load) hold_q <= sum;
  end

  assign x_val    = x_q;
  assign m1_val   = m1_q;
  assign acc_val  = acc_q;
  assign hold_val = hold_q;

endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell
  import fir_cell_pkg::*;
#(
  parameter int  OP_W  = OP_W_DEF,
  parameter int  ACC_W = ACC_W_DEF,
  parameter int  NDEC  = NDEC_DEF,
  localparam int SEL_W = $clog2(NDEC + 1),
  localparam int XW    = OP_W + 1,
  localparam int PW    = 2 * XW
) (
  input  logic             clk,
  input  logic [OP_W-1:0]  din,
  input  logic             din_tc,
  input  logic             din_en_n,
  input  logic [OP_W-1:0]  cin,
  input  logic             cin_tc,
  input  logic             cin_en_n,
  input  logic [SEL_W-1:0] decim_sel,
  input  logic             rst_n,
  input  logic             erase_n,
  input  logic             sel,
  output logic [OP_W-1:0]  cout,
  output logic             cout_tc,
  output logic [ACC_W-1:0] hold_q
);

  cell_ctl_t            ctl_q;
  logic [SEL_W-1:0]     decim_q;
  logic [OP_W-1:0]      c_val;
  logic                 c_tc;
  logic signed [XW-1:0] x_val;
  logic [PW-1:0]        m1_val;
  logic [ACC_W-1:0]     acc_val;

  fir_cell_ctl #(.SEL_W(SEL_W)) u_ctl (
    .clk       (clk),
    .din_en_n  (din_en_n),
    .cin_en_n  (cin_en_n),
    .rst_n     (rst_n),
    .erase_n   (erase_n),
    .sel       (sel),
    .decim_sel (decim_sel),
    .ctl_q     (ctl_q),
    .decim_q   (decim_q)
  );

  fir_cell_coef #(.OP_W(OP_W), .NDEC(NDEC), .SEL_W(SEL_W)) u_coef (
    .clk     (clk),
    .load_en (ctl_q.cin_en),
    .clr     (ctl_q.rst),
    .cin     (cin),
    .cin_tc  (cin_tc),
    .decim_q (decim_q),
    .c_val   (c_val),
    .c_tc    (c_tc),
    .cout    (cout),
    .cout_tc (cout_tc)
  );

  fir_cell_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mac (
    .clk      (clk),
    .ld_x     (ctl_q.din_en),
    .clr      (ctl_q.rst),
    .erase    (ctl_q.erase),
    .sel      (ctl_q.sel),
    .din      (din),
    .din_tc   (din_tc),
    .c_val    (c_val),
    .c_tc     (c_tc),
    .x_val    (x_val),
    .m1_val   (m1_val),
    .acc_val  (acc_val),
    .hold_val (hold_q)
  );

endmodule

// File: rtl/fir_mac_cell_chk.sv
module fir_mac_cell_chk #(
  parameter int  OP_W  = 8,
  parameter int  ACC_W = 26,
  parameter int  SEL_W = 2,
  localparam int XW    = OP_W + 1,
  localparam int PW    = 2 * XW
) (
  input logic             clk,
  input logic             din_en_n,
  input logic             cin_en_n,
  input logic             rst_n,
  input logic             erase_n,
  input logic             sel,
  input logic [SEL_W-1:0] decim_sel,
  input logic [OP_W-1:0]  cout,
  input logic [ACC_W-1:0] hold_q,
  input logic [XW-1:0]    x_val,
  input logic [OP_W-1:0]  c_val,
  input logic [PW-1:0]    m1_val,
  input logic [ACC_W-1:0] acc_val
);

  function automatic logic [ACC_W-1:0] sx(input logic [PW-1:0] p);
    sx = {{(ACC_W-PW){p[PW-1]}}, p};
  endfunction

  // properties look back three edges, so they wait until that many have passed
  logic [2:0] age = 3'd0;
  logic       armed;
  always_ff @(posedge clk) if (age != 3'd4) age <= age + 3'd1;
  assign armed = (age == 3'd4);

  a_r4_blank_data: assert property (@(posedge clk) disable iff (!armed)
    $past(din_en_n, 2) |-> x_val == '0);

  a_r5_coef_freeze: assert property (@(posedge clk) disable iff (!armed)
    $past(cin_en_n, 2) && $past(rst_n, 2) |-> $stable(c_val));

  a_r6_one_stage: assert property (@(posedge clk) disable iff (!armed)
    ($past(decim_sel) == SEL_W'(1)) && $past(rst_n, 2) && !$past(cin_en_n, 2)
      |-> cout == $past(c_val));

  a_r7_accumulate: assert property (@(posedge clk) disable iff (!armed)
    !$past(sel, 2) && $past(rst_n, 2)
      |-> acc_val == $past(acc_val) + sx($past(m1_val)));

  a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!armed)
    $past(sel, 2) && $past(rst_n, 2) |-> $stable(hold_q));

  a_r8_restart: assert property (@(posedge clk) disable iff (!armed)
    $past(sel, 2) && !$past(erase_n, 2) && $past(rst_n, 2)
      |-> acc_val == sx($past(m1_val)));

  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!armed)
    !$past(rst_n, 2) |-> hold_q == '0 && x_val == '0 && c_val == '0 && m1_val == '0);

  a_r11_wipe: assert property (@(posedge clk) disable iff (!armed)
    !$past(rst_n, 2) && !$past(erase_n, 2) |-> acc_val == '0);

endmodule

bind fir_mac_cell fir_mac_cell_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .din_en_n  (din_en_n),
  .cin_en_n  (cin_en_n),
  .rst_n     (rst_n),
  .erase_n   (erase_n),
  .sel       (sel),
  .decim_sel (decim_sel),
  .cout      (cout),
  .hold_q    (hold_q),
  .x_val     (x_val),
  .c_val     (c_val),
  .m1_val    (m1_val),
  .acc_val   (acc_val)
);

// File: tb/fir_mac_cell_tb.sv
module fir_mac_cell_tb;

  localparam int CLK_NS = 10;
  localparam int K      = 8;
  localparam int NB     = 40;
  localparam int NS     = NB * K;

  logic        clk = 1'b0;
  logic [7:0]  din = '0, cin = '0;
  logic        din_tc = 1'b0, cin_tc = 1'b0;
  logic        din_en_n = 1'b1, cin_en_n = 1'b1;
  logic [1:0]  decim_sel = '0;
  logic        rst_n = 1'b0, erase_n = 1'b0, sel = 1'b0;
  logic [7:0]  cout;
  logic        cout_tc;
  logic [25:0] hold_q;

  always #(CLK_NS/2) clk = ~clk;

  fir_mac_cell u_dut (
    .clk(clk), .din(din), .din_tc(din_tc), .din_en_n(din_en_n),
    .cin(cin), .cin_tc(cin_tc), .cin_en_n(cin_en_n), .decim_sel(decim_sel),
    .rst_n(rst_n), .erase_n(erase_n), .sel(sel),
    .cout(cout), .cout_tc(cout_tc), .hold_q(hold_q)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint opv(input logic [7:0] v, input logic tc);
    return tc ? longint'($signed(v)) : longint'(v);
  endfunction

  function automatic longint wrap26(input longint v);
    longint t;
    t = v & 64'h3FF_FFFF;
    if (t >= 64'h200_0000) t = t - 64'h400_0000;
    return t;
  endfunction

  function automatic longint hv();
    return longint'($signed(hold_q));
  endfunction

  logic [7:0] xs [NS];
  logic [7:0] cs [NS];
  logic       xt [NS];
  logic       ct [NS];
  logic       ddis [NS];
  logic       chold [NS];
  longint     ex [NS];
  longint     ec [NS];
  longint     blk [NB];
  logic [7:0] dq [12];
  logic       dt [12];

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R2 watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < NB; b++) blk[b] = 0;
    for (int i = 0; i < NS; i++) begin
      xs[i] = 8'($urandom);
      cs[i] = 8'($urandom);
      xt[i] = 1'($urandom);
      ct[i] = 1'($urandom);
      ddis[i]  = (($urandom % 8) == 0) && (i < NS - 1);
      chold[i] = (($urandom % 10) == 0);
      ex[i] = (i > 0 && ddis[i-1]) ? 0 : opv(xs[i], xt[i]);
      ec[i] = (i > 0 && chold[i-1]) ? ec[i-1] : opv(cs[i], ct[i]);
      blk[i / K] += ex[i] * ec[i];
    end

    // reset with erase: everything zero (R10, R11)
    repeat (4) @(negedge clk);
    chk("R11 reset state hold", hv(), 0);
    chk("R10 reset state cout", longint'(cout), 0);
    rst_n = 1'b1; erase_n = 1'b1; din_en_n = 1'b0; cin_en_n = 1'b0;

    // streamed products, one restart every K loads (R1 R2 R3 R4 R5 R7 R8)
    for (int i = 0; i < NS + 5; i++) begin
      @(negedge clk);
      if (i >= K + 3 && ((i - 3) % K) == 0)
        chk($sformatf("R1/R2/R3/R4/R5/R7 group %0d sum", (i - 3) / K - 1),
            hv(), wrap26(blk[(i - 3) / K - 1]));
      if (i >= K + 4 && ((i - 4) % K) == 0)
        chk($sformatf("R8 group %0d held during restart", (i - 4) / K - 1),
            hv(), wrap26(blk[(i - 4) / K - 1]));
      if (i < NS) begin
        din = xs[i]; din_tc = xt[i]; cin = cs[i]; cin_tc = ct[i];
        din_en_n = ddis[i]; cin_en_n = chold[i];
      end else begin
        din = '0; din_tc = 1'b0; cin = '0; cin_tc = 1'b0;
        din_en_n = 1'b0; cin_en_n = 1'b0;
      end
      sel     = ((i % K) == 2);
      erase_n = !((i % K) == 2);
    end
    sel = 1'b0; erase_n = 1'b1;

    // decimation depth on the coefficient path (R6)
    for (int d = 0; d < 4; d++) begin
      decim_sel = 2'(d);
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (i >= 5) begin
          chk($sformatf("R6 depth %0d cout", d), longint'(cout), longint'(dq[i-1-d]));
          chk($sformatf("R6 depth %0d cout_tc", d), longint'(cout_tc), longint'(dt[i-1-d]));
        end
        dq[i] = 8'($urandom);
        dt[i] = 1'($urandom);
        cin = dq[i]; cin_tc = dt[i]; din = '0;
      end
    end

    // clear controls: erase without select, reset alone, reset with erase
    for (int t = 0; t < 18; t++) begin
      @(negedge clk);
      case (t)
        8:  chk("R7 settled sum", hv(), 60);
        10: chk("R9 erase unselected", hv(), 60);
        11: chk("R9 erase unselected later", hv(), 60);
        13: begin
              chk("R10 hold cleared", hv(), 0);
              chk("R10 cout cleared", longint'(cout), 0);
            end
        14: chk("R10 accumulator kept", hv(), 60);
        16: chk("R11 hold cleared", hv(), 0);
        17: chk("R11 accumulator cleared", hv(), 0);
        default: ;
      endcase
      din = (t < 4) ? 8'd3 : 8'd0;
      din_tc = 1'b0; cin = 8'd5; cin_tc = 1'b0;
      din_en_n = (t >= 4);
      sel      = (t == 2);
      erase_n  = !(t == 2 || t == 8 || t == 14);
      rst_n    = !(t == 11 || t == 14);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule